// File: doc/BRIEF.md
# Rectangular Overlay Clipping Engine

This block decides, pixel by pixel, whether a point of a video window lies beneath one or more rectangular overlay windows and must therefore be suppressed. Up to sixteen overlays are described by two sorted edge lists held in a small table. The column list marks where each overlay's horizontal extent begins and ends. The row list does the same vertically. Each list word pairs a coordinate with a full snapshot of per-overlay flags. Edges of different overlays that fall on the same coordinate are merged into one word.

While a field is scanned, a row tracker and a column tracker walk their lists alongside the row and column counters. Each copies the flag snapshot of a reached entry into its own flag register. A pixel is hidden when some overlay has its flag set in both registers: a bitwise AND followed by an OR-reduction. Overlapping overlays therefore need no special treatment when the lists are built. Coordinates always refer to the full target window. When the video is written interlaced, the row tracker works from the interleaved row number.

Top module: `rect_clip_engine`

## Requirements
- R1: A table word carries the coordinate in bits [31:16] and one flag per overlay in bits [15:0], with bit k belonging to overlay k. Table entries 0 to 31 form the column list and entries 32 to 63 form the row list. A word is stored on a clock edge with `tbl_we` high.
- R2: After reset `clip_valid` and `clip_out` are low, and both flag registers start as all-visible (zero).
- R3: A pixel at column x of target row y is hidden (`clip_out` = 1) exactly when some overlay k has left <= x <= right and top <= y <= bottom. The entry at left/top sets flag k and the entry at right+1/bottom+1 clears it.
- R4: Overlapping or touching overlays hide the union of their areas. Neither list encodes any overlap information.
- R5: The column flags take an entry's snapshot on the pixel whose column count equals that entry's coordinate, and that snapshot already applies to that pixel. They hold through cycles without `pix_valid`. Each `line_start` returns the column pointer to entry 0 and clears the column flags.
- R6: On `line_start` the row flags take the snapshot of the next row entry whose coordinate is at or below the effective row, and hold otherwise. `field_start` clears the row flags and the row pointer, and restarts the row count at 0.
- R7: An entry with coordinate 0 at a list index other than 0 ends that list. Entries stored after it never take effect. Index 0 with coordinate 0 is an ordinary entry, so an overlay may begin at row or column 0.
- R8: With `interlaced` sampled high at `field_start`, the effective row is twice the row count within the field plus the `field_odd` bit sampled at `field_start`. An entry whose row is stepped over takes effect on the first row past it. When two entries are passed at once, the later snapshot wins.
- R9: `clip_valid` is `pix_valid` delayed by one clock, and `clip_out` belongs to the pixel strobed in that earlier cycle.
- R10: A list that fills all 32 of its entries with no end marker is used to its last entry, and the pointer then stops without reading into the other list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write address |
| tbl_wdata | input | 32 | Table write word: coordinate and overlay flags |
| field_start | input | 1 | Start-of-field pulse |
| field_odd | input | 1 | Field parity, sampled at field start |
| interlaced | input | 1 | Interlaced target addressing, sampled at field start |
| line_start | input | 1 | Start-of-row pulse, given before the row's pixels |
| pix_valid | input | 1 | Pixel strobe |
| clip_out | output | 1 | 1 = pixel hidden by an overlay |
| clip_valid | output | 1 | Qualifies clip_out |

## Verification
On every cycle the assertions check the one-cycle alignment of `clip_valid` with the pixel strobe. They also check the clearing of pointers and flags at row and field starts, that flags and pointers hold between events, that each pointer moves forward by a bounded step, and that neither pointer runs past its half of the table. Whether the hidden area matches the overlay rectangles, whether the union is correct for overlaps, how end markers and stale words past them are handled, and how stepped-over rows behave in either field parity can only be shown by the bench's sweeps. Those sweeps cover every pixel of small windows and compare each result with a direct rectangle test.

// File: rtl/rclip_pkg.sv
package rclip_pkg;
  localparam int DEF_NWIN  = 16;
  localparam int DEF_CW    = 16;
  localparam int DEF_DEPTH = 64;

  // Row number seen by the row list: interleaved when interlaced
  function automatic logic [DEF_CW-1:0] eff_row(input logic [DEF_CW-1:0] cnt,
                                                input logic par, input logic ilace);
    eff_row = ilace ? {cnt[DEF_CW-2:0], par} : cnt;
  endfunction
endpackage

// File: rtl/rclip_table.sv
module rclip_table #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // distributed-RAM style asynchronous reads
  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
endmodule

// File: rtl/rclip_col_tracker.sv
module rclip_col_tracker #(
  parameter int NWIN = 16,
  parameter int CW   = 16,
  parameter int HALF = 32,
  localparam int PW  = $clog2(HALF) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start,
  input  logic            pix_valid,
  output logic [PW-2:0]   rd_addr,
  input  logic [CW-1:0]   ent_coord,
  input  logic [NWIN-1:0] ent_flags,
  output logic [NWIN-1:0] cur_flags
);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic [PW-1:0]   ptr;
  logic [CW-1:0]   col;
  logic [NWIN-1:0] flags;
  logic            avail, hit;

  assign rd_addr = ptr[PW-2:0];
  assign avail   = (ptr < HALF_P) && ((ptr == '0) || (ent_coord != '0));
  assign hit     = pix_valid && avail && (ent_coord == col);
  assign cur_flags = hit ? ent_flags : flags;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      ptr   <= '0;
      col   <= '0;
      flags <= '0;
    end else if (pix_valid) begin
      col <= col + 1'b1;
      if (hit) begin
        flags <= ent_flags;
        ptr   <= ptr + 1'b1;
      end
    end
  end

  assert_col_restart_R5: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (ptr == '0) && (flags == '0));
  assert_col_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !pix_valid) |=> $stable(flags) && $stable(ptr));
  assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> (ptr == $past(ptr)) || (ptr == $past(ptr) + 1'b1));
  assert_col_bound_R10: assert property (@(posedge clk) disable iff (rst)
    ptr <= HALF_P);
endmodule

// File: rtl/rclip_row_tracker.sv
module rclip_row_tracker
  import rclip_pkg::*;
#(
  parameter int NWIN = 16,
  parameter int CW   = 16,
  parameter int HALF = 32,
  localparam int PW  = $clog2(HALF) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            field_start,
  input  logic            field_odd,
  input  logic            interlaced,
  input  logic            line_start,
  output logic [PW-2:0]   rd_addr0,
  output logic [PW-2:0]   rd_addr1,
  input  logic [CW-1:0]   c0,
  input  logic [NWIN-1:0] f0,
  input  logic [CW-1:0]   c1,
  input  logic [NWIN-1:0] f1,
  output logic [NWIN-1:0] row_flags
);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic [PW-1:0] ptr, ptr1;
  logic [CW-1:0] cnt, eff;
  logic          par_q, ilace_q;
  logic          a0, a1, pass0, pass1;

  assign ptr1     = ptr + 1'b1;
  assign rd_addr0 = ptr[PW-2:0];
  assign rd_addr1 = ptr1[PW-2:0];

  always_comb begin
    if (CW == DEF_CW) eff = CW'(eff_row(DEF_CW'(cnt), par_q, ilace_q));
    else              eff = ilace_q ? {cnt[CW-2:0], par_q} : cnt;
  end

  assign a0    = (ptr < HALF_P) && ((ptr == '0) || (c0 != '0));
  assign a1    = (ptr1 < HALF_P) && (c1 != '0);
  assign pass0 = a0 && (c0 <= eff);
  assign pass1 = pass0 && a1 && (c1 <= eff);

  always_ff @(posedge clk) begin
    if (rst || field_start) begin
      ptr       <= '0;
      cnt       <= '0;
      row_flags <= '0;
      par_q     <= rst ? 1'b0 : field_odd;
      ilace_q   <= rst ? 1'b0 : interlaced;
    end else if (line_start) begin
      cnt <= cnt + 1'b1;
      if (pass1) begin
        row_flags <= f1;
        ptr       <= ptr + 2'd2;
      end else if (pass0) begin
        row_flags <= f0;
        ptr       <= ptr1;
      end
    end
  end

  assert_row_field_clear_R6: assert property (@(posedge clk) disable iff (rst)
    field_start |=> (row_flags == '0) && (ptr == '0));
  assert_row_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!field_start && !line_start) |=> $stable(row_flags) && $stable(ptr));
  assert_row_step_R8: assert property (@(posedge clk) disable iff (rst)
    !field_start |=> (ptr >= $past(ptr)) && (ptr <= $past(ptr) + 2'd2));
  assert_row_bound_R10: assert property (@(posedge clk) disable iff (rst)
    ptr <= HALF_P);
endmodule

// File: rtl/rect_clip_engine.sv
module rect_clip_engine
  import rclip_pkg::*;
#(
  parameter int NWIN  = DEF_NWIN,
  parameter int CW    = DEF_CW,
  parameter int DEPTH = DEF_DEPTH,
  localparam int W    = CW + NWIN,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [W-1:0]  tbl_wdata,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          interlaced,
  input  logic          line_start,
  input  logic          pix_valid,
  output logic          clip_out,
  output logic          clip_valid
);
  logic [AW-2:0]   col_addr, row_addr0, row_addr1;
  logic [W-1:0]    col_word, row_word0, row_word1;
  logic [NWIN-1:0] col_flags, row_flags;

  rclip_table #(.W(W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .ra0({1'b0, col_addr}), .ra1({1'b1, row_addr0}), .ra2({1'b1, row_addr1}),
    .rd0(col_word), .rd1(row_word0), .rd2(row_word1)
  );

  rclip_col_tracker #(.NWIN(NWIN), .CW(CW), .HALF(HALF)) u_col (
    .clk(clk), .rst(rst), .line_start(line_start), .pix_valid(pix_valid),
    .rd_addr(col_addr), .ent_coord(col_word[W-1:NWIN]),
    .ent_flags(col_word[NWIN-1:0]), .cur_flags(col_flags)
  );

  rclip_row_tracker #(.NWIN(NWIN), .CW(CW), .HALF(HALF)) u_row (
    .clk(clk), .rst(rst), .field_start(field_start), .field_odd(field_odd),
    .interlaced(interlaced), .line_start(line_start),
    .rd_addr0(row_addr0), .rd_addr1(row_addr1),
    .c0(row_word0[W-1:NWIN]), .f0(row_word0[NWIN-1:0]),
    .c1(row_word1[W-1:NWIN]), .f1(row_word1[NWIN-1:0]),
    .row_flags(row_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clip_out   <= 1'b0;
      clip_valid <= 1'b0;
    end else begin
      clip_valid <= pix_valid;
      clip_out   <= pix_valid && (|(row_flags & col_flags));
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> clip_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !clip_valid && !clip_out);
endmodule

// File: tb/rect_clip_engine_bench.sv
module rect_clip_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic field_start = 1'b0, field_odd = 1'b0, interlaced = 1'b0;
  logic line_start = 1'b0, pix_valid = 1'b0;
  logic clip_out, clip_valid;

  int errors = 0, checks = 0, cyc = 0;
  int wl[16], wr[16], wt[16], wb[16];
  int nw = 0;

  always #5 clk = ~clk;

  rect_clip_engine u_rect_clip_engine (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .field_start(field_start), .field_odd(field_odd),
    .interlaced(interlaced), .line_start(line_start), .pix_valid(pix_valid),
    .clip_out(clip_out), .clip_valid(clip_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cover_vec(input bit rows, input int c);
    logic [15:0] v = '0;
    for (int k = 0; k < nw; k++)
      if (rows ? (wt[k] <= c && c <= wb[k]) : (wl[k] <= c && c <= wr[k])) v[k] = 1'b1;
    return v;
  endfunction

  function automatic bit hidden(input int x, input int y);
    for (int k = 0; k < nw; k++)
      if (wl[k] <= x && x <= wr[k] && wt[k] <= y && y <= wb[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic twrite(input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // R1: column list at 0..31, row list at 32..63; word = {coord, flags}
  task automatic build_list(input bit rows);
    int idx = 0, lastc = 0;
    logic [15:0] prev = '0, v;
    int base = rows ? 32 : 0;
    for (int c = 0; c < 64; c++) begin
      v = cover_vec(rows, c);
      if ((c == 0 || v != prev) && idx < 32) begin
        twrite(base + idx, {16'(c), v});
        idx++; lastc = c; prev = v;
      end
    end
    if (idx < 32) twrite(base + idx, 32'h0);
    // R7: stale word after the end marker must never act
    if (idx + 1 < 32) twrite(base + idx + 1, {16'(lastc + 1), 16'hFFFF});
  endtask

  task automatic load_windows();
    for (int a = 0; a < 64; a++) twrite(a, 32'h0);
    build_list(1'b0);
    build_list(1'b1);
  endtask

  task automatic start_field(input bit ilace, input bit odd);
    @(negedge clk);
    field_start = 1'b1; interlaced = ilace; field_odd = odd; pix_valid = 1'b0;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic run_row(input int y, input int width, input int gap_every);
    @(negedge clk);
    pix_valid = 1'b0; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int x = 0; x < width; x++) begin
      pix_valid = 1'b1;
      @(posedge clk); #1;
      check(clip_valid == 1'b1, "R9 valid", int'(clip_valid), 1);
      check(clip_out == hidden(x, y), "R3/R4/R5/R6 pixel", int'(clip_out), int'(hidden(x, y)));
      @(negedge clk);
      if (gap_every != 0 && (x % gap_every) == gap_every - 1) begin
        pix_valid = 1'b0;
        @(posedge clk); #1;
        check(clip_valid == 1'b0 && clip_out == 1'b0, "R9/R5 gap", int'(clip_valid), 0);
        @(negedge clk);
      end
    end
    pix_valid = 1'b0;
  endtask

  task automatic sweep(input bit ilace, input bit odd, input int rows, input int width, input int gap);
    start_field(ilace, odd);
    for (int i = 0; i < rows; i++) run_row(ilace ? 2 * i + int'(odd) : i, width, gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(clip_out == 1'b0 && clip_valid == 1'b0, "R2 reset", int'(clip_out), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(clip_valid == 1'b0, "R2 reset idle", int'(clip_valid), 0);

    // overlapping, touching and origin-anchored overlays (R3 R4 R7)
    nw = 4;
    wl[0] = 0;  wr[0] = 3;  wt[0] = 0;  wb[0] = 2;
    wl[1] = 5;  wr[1] = 8;  wt[1] = 1;  wb[1] = 3;
    wl[2] = 7;  wr[2] = 12; wt[2] = 3;  wb[2] = 9;
    wl[3] = 13; wr[3] = 16; wt[3] = 6;  wb[3] = 6;
    load_windows();
    sweep(1'b0, 1'b0, 14, 20, 3);
    // interlaced both parities (R8)
    sweep(1'b1, 1'b0, 7, 20, 0);
    sweep(1'b1, 1'b1, 7, 20, 5);

    // single-row overlay at odd row: both edges stepped over at once (R8)
    nw = 2;
    wl[0] = 2; wr[0] = 6; wt[0] = 3; wb[0] = 3;
    wl[1] = 9; wr[1] = 9; wt[1] = 5; wb[1] = 7;
    load_windows();
    sweep(1'b1, 1'b0, 6, 12, 0);
    sweep(1'b1, 1'b1, 6, 12, 0);
    sweep(1'b0, 1'b0, 10, 12, 0);

    // sixteen one-column overlays fill the column list completely (R10)
    nw = 16;
    for (int k = 0; k < 16; k++) begin
      wl[k] = 2 * k; wr[k] = 2 * k; wt[k] = 1 + (k % 3); wb[k] = 3 + (k % 2);
    end
    load_windows();
    sweep(1'b0, 1'b0, 6, 40, 0);
    sweep(1'b0, 1'b0, 6, 40, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule